// File: doc/BRIEF.md
# Asynchronous Handshake Bus Register Target

This block is a slave on a shared bus where a master and a slave move data with a pair of strobes rather than a common clock. The master places an address, a two-bit transfer code and, for writes, a data word on the bus. It then raises its sync strobe. The target carries that strobe into its own clock domain through a two-stage synchronizer. It then checks whether the address falls inside its register window. If it does, it either captures the write or latches the read data, and only then raises its own sync reply. The reply stays up until the master withdraws its strobe. So a master of any speed, fast or slow, completes the handshake.

The register window sits near the top of the address space, where device registers live. It holds a small file of 16-bit registers, addressed by byte address with each register on an even boundary. There are four transfer kinds: read, paused read, word write and byte write. A paused read opens a read-modify-write. From then on the target serves nothing but a write to that same register, which closes the sequence. A power-fail warning input stops every write from changing storage. The target still completes the handshake, so the master is not left stalled.

Top module: `abus_target`

## Requirements
- R1: After reset the reply strobe is low and every register in the window reads as zero.
- R2: Transfer code 00 is a read. The reply strobe rises a few clock cycles after the master strobe. When it rises, the read data output already holds the addressed register.
- R3: Once raised, the reply strobe stays high as long as the master strobe is held. It falls within a few clock cycles of the master strobe falling.
- R4: Transfer code 10 is a word write. It replaces all 16 bits of the addressed register. Address bit 0 has no effect.
- R5: Transfer code 11 is a byte write. With address bit 0 at 1 it writes data bits 15:8 into the register's upper byte. With bit 0 at 0 it writes bits 7:0 into the lower byte. The other byte keeps its value.
- R6: The window runs from byte address 0x3FF00 to 0x3FF0F and holds eight registers, with register n at 0x3FF00 + 2n. An access outside it is never answered and changes no register.
- R7: Transfer code 01 is a paused read. It returns data like a read. Until it is completed, any access other than a write to the same register gets no reply.
- R8: A word or byte write to the paused register is answered, stored, and ends the pause. Other accesses are then served again.
- R9: While the power-fail warning is high, writes are answered but leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 18 | Byte address from the master |
| bus_ctl | input | 2 | Transfer code (00 read, 01 paused read, 10 word write, 11 byte write) |
| bus_wdata | input | 16 | Write data from the master |
| bus_msync | input | 1 | Master sync strobe, asynchronous |
| bus_pwrfail | input | 1 | Power-fail warning, asynchronous |
| bus_rdata | output | 16 | Read data, valid while the reply strobe is high |
| bus_ssync | output | 1 | Slave sync reply strobe |

## Verification
The hardest state to reach from the ports is a read-modify-write that is still open while another master tries to use the target. The stimulus issues a paused read and then starts a read and a write to other registers. Each of these is held for a dozen cycles while the bench watches that no reply comes, and then it is abandoned. Only after that does the closing byte write go in. A later read of the previously refused register shows that the lock has lifted.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [1:0] {
    CYC_READ   = 2'b00,
    CYC_RDPAUS = 2'b01,
    CYC_WWORD  = 2'b10,
    CYC_WBYTE  = 2'b11
  } abus_cyc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } abus_state_e;

  // true when a byte address lies in [base, base + 2*nregs)
  function automatic logic in_window(input logic [17:0] a,
                                     input logic [17:0] base,
                                     input int unsigned nregs);
    logic [18:0] top;
    top = {1'b0, base} + 19'(2 * nregs);
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < top);
  endfunction

  // register number for a byte address inside the window
  function automatic logic [17:0] word_index(input logic [17:0] a,
                                             input logic [17:0] base);
    logic [17:0] off;
    off = a - base;
    return {1'b0, off[17:1]};
  endfunction

  // byte-lane enables for a two-lane data path
  function automatic logic [1:0] lane_mask(input logic [1:0] ctl,
                                           input logic a0);
    logic [1:0] m;
    if (ctl == CYC_WBYTE) begin
      m = 2'b00;
      m[a0] = 1'b1;
    end else begin
      m = 2'b11;
    end
    return m;
  endfunction

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/abus_decode.sv
module abus_decode
  import abus_pkg::*;
#(
  parameter int          ADDR_W = 18,
  parameter int          NREGS  = 8,
  parameter logic [17:0] BASE   = 18'h3FF00,
  localparam int         IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [17:0] full_idx;

  assign hit      = in_window(addr, BASE, NREGS);
  assign full_idx = word_index(addr, BASE);
  assign idx      = full_idx[IDX_W-1:0];
endmodule

// File: rtl/abus_regfile.sv
module abus_regfile #(
  parameter  int DATA_W = 16,
  parameter  int NREGS  = 8,
  localparam int IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [NREGS-1:0][DATA_W-1:0] mem_q;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem_q[r][l*8 +: 8] <= '0;
        else if (we && be[l] && idx == IDX_W'(r))
          mem_q[r][l*8 +: 8] <= wdata[l*8 +: 8];
      end
    end
  end

  assign rdata = mem_q[idx];

  // R9
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(mem_q));
endmodule

// File: rtl/abus_target.sv
module abus_target
  import abus_pkg::*;
#(
  parameter  int          ADDR_W = 18,
  parameter  int          DATA_W = 16,
  parameter  int          NREGS  = 8,
  parameter  logic [17:0] BASE   = 18'h3FF00,
  localparam int          IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int          LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_ctl,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_msync,
  input  logic              bus_pwrfail,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ssync
);
  logic              msync_s, pf_s;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_word;
  logic [LANES-1:0]  be;
  logic              is_write, lock_block, start_evt, wr_en;
  abus_state_e       state_q;
  logic              ssync_q, lock_q;
  logic [IDX_W-1:0]  lock_idx_q;
  logic [DATA_W-1:0] rdata_q;

  abus_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_pwrfail, bus_msync}),
    .q({pf_s, msync_s})
  );

  abus_decode #(.ADDR_W(ADDR_W), .NREGS(NREGS), .BASE(BASE)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  // named internal events
  assign is_write   = bus_ctl[1];
  assign lock_block = lock_q && !(is_write && idx == lock_idx_q);
  assign start_evt  = (state_q == ST_IDLE) && msync_s && hit && !lock_block;
  assign wr_en      = start_evt && is_write && !pf_s;
  assign be         = lane_mask(bus_ctl, bus_addr[0]);

  abus_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .be(be), .idx(idx),
    .wdata(bus_wdata), .rdata(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ssync_q    <= 1'b0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      rdata_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_evt) begin
          state_q <= ST_ACK;
          ssync_q <= 1'b1;
          if (!is_write) rdata_q <= rd_word;
          if (abus_cyc_e'(bus_ctl) == CYC_RDPAUS) begin
            lock_q     <= 1'b1;
            lock_idx_q <= idx;
          end else if (is_write) begin
            lock_q <= 1'b0;
          end
        end
        ST_ACK: if (!msync_s) begin
          state_q <= ST_IDLE;
          ssync_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_ssync = ssync_q;
  assign bus_rdata = rdata_q;

  // R2
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssync_q) |-> $past(msync_s));
  // R3
  hold_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssync_q) |-> !$past(msync_s));
  // R6
  window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssync_q) |-> $past(hit));
  // R8
  unlock_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(start_evt && is_write));
  // R7
  lock_same_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && start_evt) |-> (idx == lock_idx_q));
endmodule

// File: tb/abus_target_bench.sv
module abus_target_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic [1:0]  ctl = '0;
  logic [15:0] wdata = '0;
  logic        msync = 1'b0;
  logic        pwrfail = 1'b0;
  logic [15:0] rdata;
  logic        ssync;

  int checks = 0;
  int fails = 0;
  int low_cnt = 0;
  int cycles = 0;
  logic [15:0] model [8];

  localparam logic [17:0] BASE = 18'h3FF00;

  always #10 clk = ~clk;

  abus_target u_abus_target (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_ctl(ctl),
    .bus_wdata(wdata), .bus_msync(msync), .bus_pwrfail(pwrfail),
    .bus_rdata(rdata), .bus_ssync(ssync)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every clock: reply must not linger once master strobe has been low a while (R3)
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (!msync) low_cnt++; else low_cnt = 0;
      if (low_cnt >= 5) check(!ssync, "R3 idle reply", {15'd0, ssync}, 16'd0);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // one bus transfer; model updated from the requirement rules
  task automatic xfer(input logic [17:0] a, input logic [1:0] c,
                      input logic [15:0] wd, input bit exp_ack, input string req);
    bit got;
    int ri;
    got = 1'b0;
    ri = int'((a - BASE) >> 1) & 7;
    @(negedge clk);
    addr = a; ctl = c; wdata = wd; msync = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ssync) begin got = 1'b1; break; end
    end
    check(got == exp_ack, {req, " reply"}, {15'd0, got}, {15'd0, exp_ack});
    if (got) begin
      if (!c[1]) check(rdata == model[ri], {req, " rdata"}, rdata, model[ri]);
      else if (!pwrfail) begin
        if (c == 2'b10) model[ri] = wd;
        else if (a[0]) model[ri][15:8] = wd[15:8];
        else model[ri][7:0] = wd[7:0];
      end
      repeat (4) @(negedge clk);
      check(ssync, "R3 held", {15'd0, ssync}, 16'd1);
      msync = 1'b0;
      repeat (4) @(negedge clk);
      check(!ssync, "R3 released", {15'd0, ssync}, 16'd0);
    end else begin
      msync = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(!ssync, "R1 reset reply", {15'd0, ssync}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(BASE + 18'd6, 2'b00, 16'h0, 1'b1, "R1 reset read");
    // R4 word writes, bit 0 ignored
    xfer(BASE + 18'd0, 2'b10, 16'h1234, 1'b1, "R4 write r0");
    xfer(BASE + 18'd5, 2'b10, 16'hBEEF, 1'b1, "R4 write odd r2");
    xfer(BASE + 18'd14, 2'b10, 16'hA5A5, 1'b1, "R4 write r7");
    xfer(BASE + 18'd0, 2'b00, 16'h0, 1'b1, "R2 read r0");
    xfer(BASE + 18'd4, 2'b00, 16'h0, 1'b1, "R2 read r2");
    xfer(BASE + 18'd14, 2'b00, 16'h0, 1'b1, "R2 read r7");
    // R5 byte lanes
    xfer(BASE + 18'd1, 2'b11, 16'h77FF, 1'b1, "R5 upper r0");
    xfer(BASE + 18'd14, 2'b11, 16'hFF3C, 1'b1, "R5 lower r7");
    xfer(BASE + 18'd0, 2'b00, 16'h0, 1'b1, "R5 read r0");
    xfer(BASE + 18'd14, 2'b00, 16'h0, 1'b1, "R5 read r7");
    // R6 outside window
    xfer(BASE - 18'd2, 2'b10, 16'hDEAD, 1'b0, "R6 below");
    xfer(BASE + 18'd16, 2'b10, 16'hDEAD, 1'b0, "R6 above");
    xfer(18'h00010, 2'b00, 16'h0, 1'b0, "R6 low read");
    for (int i = 0; i < 8; i++)
      xfer(BASE + 18'(2 * i), 2'b00, 16'h0, 1'b1, "R6 sweep");
    // R7 / R8 read-modify-write lock
    xfer(BASE + 18'd6, 2'b01, 16'h0, 1'b1, "R7 paused read r3");
    xfer(BASE + 18'd8, 2'b00, 16'h0, 1'b0, "R7 blocked read r4");
    xfer(BASE + 18'd10, 2'b10, 16'h5555, 1'b0, "R7 blocked write r5");
    xfer(BASE + 18'd6, 2'b01, 16'h0, 1'b0, "R7 blocked repause r3");
    xfer(BASE + 18'd7, 2'b11, 16'hC300, 1'b1, "R8 complete r3");
    xfer(BASE + 18'd8, 2'b00, 16'h0, 1'b1, "R8 unlocked read r4");
    xfer(BASE + 18'd6, 2'b00, 16'h0, 1'b1, "R8 read r3");
    // R9 power-fail
    pwrfail = 1'b1;
    repeat (4) @(negedge clk);
    xfer(BASE + 18'd4, 2'b10, 16'h0BAD, 1'b1, "R9 word inhibited");
    xfer(BASE + 18'd1, 2'b11, 16'hEE00, 1'b1, "R9 byte inhibited");
    pwrfail = 1'b0;
    repeat (4) @(negedge clk);
    xfer(BASE + 18'd4, 2'b00, 16'h0, 1'b1, "R9 read r2");
    xfer(BASE + 18'd0, 2'b00, 16'h0, 1'b1, "R9 read r0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule